// File: doc/BRIEF.md
# Programmable Strobe-Line Sequencer with Wait

This block turns a stream of per-step timing words into two general-purpose strobe levels for an external memory device. Each step lasts two system clocks, a first and a second half-phase. Four bits of the word set the two lines: for each line, one bit gives the level at the end of the first half and one gives the level at the end of the second half. The word fetcher holds a word on `word_i` for the whole step. It moves to the next word at every clock edge where `phase_o` is 1 and `stall_o` is 0.

A mode input turns line 4 into a wait input. In that mode the two bits that would time line 4 take on two other jobs. The first-half bit becomes a wait enable. The second-half bit chooses the read capture edge, which the block reports as a one-cycle `capture_o` pulse. When a step with the enable set ends while the synchronized wait input is high, the block freezes its outputs and raises `stall_o` until wait is seen low again.

Top module: `strobe_seq`

## Requirements
- R1: During reset, and after any first-phase edge with `word_valid_i` low while not frozen, `line4_o` and `line5_o` are 1 and `capture_o`, `stall_o` and `phase_o` are 0.
- R2: A valid word takes exactly two clocks. `phase_o` is 0 during the first half-phase and 1 during the second, and the word is consumed at the edge that ends the second half-phase.
- R3: `line5_o` takes word bit 18 at the end of the first half-phase and word bit 19 at the end of the second.
- R4: With `wait_mode_i` = 0, `line4_o` takes word bit 16 at the end of the first half-phase and bit 17 at the end of the second. `wait_i` has no effect and `stall_o` stays 0.
- R5: With `wait_mode_i` = 1, `line4_o` stays 1. Word bit 16 acts as the wait enable and word bit 17 as the capture-edge select.
- R6: For a word with `read_i` = 1, a select of 0 (or `wait_mode_i` = 0) makes `capture_o` 1 during the second half-phase cycle. A select of 1 makes it 1 during the cycle after the second half-phase. Otherwise `capture_o` is 0.
- R7: In wait mode with the wait enable at 0, a high `wait_i` causes no stall and the outputs follow the word.
- R8: In wait mode with the enable at 1, if `wait_i` has been high for at least two clock edges before the edge that ends the second half-phase, then `stall_o` rises at that edge. The lines then hold their values for the whole freeze, and `capture_o` is 0 from the first edge inside the freeze on.
- R9: After `wait_i` falls between two edges, `stall_o` falls at the third rising edge that follows. The held word's first half-phase ends at the next edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, two per step |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | A timing word is present |
| word_i | input | WORD_W | Current timing word |
| read_i | input | 1 | Current step belongs to a read |
| wait_mode_i | input | 1 | 1: line 4 acts as the wait input |
| wait_i | input | 1 | Asynchronous wait request |
| line4_o | output | 1 | Strobe line 4 level |
| line5_o | output | 1 | Strobe line 5 level |
| capture_o | output | 1 | Read data capture strobe |
| stall_o | output | 1 | Fetcher must hold its word |
| phase_o | output | 1 | 0 first half-phase, 1 second |

## Verification
The bench runs every combination of the four timing bits, the mode and the read flag. It does this once with wait low and once with wait high, always leaving out the single combination that freezes. The wait-high pass tells an ignored wait apart from an honoured one in both modes. A directed sequence then enters a freeze with the late capture edge selected. It checks that the lines hold and that capture drops, counts the exact edges to release, and confirms that the held word runs afterwards with its own timing. Idle gaps between the passes check the return to the inactive levels.

// File: rtl/strobe_seq_pkg.sv
`timescale 1ns/1ps
package strobe_seq_pkg;
  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} half_t;

  typedef struct packed {
    logic l4_early;
    logic l4_late;
    logic l5_early;
    logic l5_late;
    logic wait_en;
    logic late_capture;
  } step_ctl_t;
endpackage

// File: rtl/strobe_wait_sync.sv
`timescale 1ns/1ps
module strobe_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= 1'b0;
    else         stg_q[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  if (STAGES >= 2) begin : g_chk
    AST_SYNC_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sync_o) |-> (sync_o == $past(stg_q[STAGES-2]))); // R9
  end
endmodule

// File: rtl/strobe_word_decode.sv
`timescale 1ns/1ps
module strobe_word_decode
  import strobe_seq_pkg::*;
#(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned L4_EARLY_BIT = 16,
  parameter int unsigned L4_LATE_BIT  = 17,
  parameter int unsigned L5_EARLY_BIT = 18,
  parameter int unsigned L5_LATE_BIT  = 19
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              wait_mode_i,
  output step_ctl_t         ctl_o
);
  logic unused_word;
  assign unused_word = ^word_i;

  // line-4 bits are reinterpreted in wait mode; the line itself parks high
  always_comb begin
    ctl_o.l5_early     = word_i[L5_EARLY_BIT];
    ctl_o.l5_late      = word_i[L5_LATE_BIT];
    ctl_o.l4_early     = wait_mode_i ? 1'b1 : word_i[L4_EARLY_BIT];
    ctl_o.l4_late      = wait_mode_i ? 1'b1 : word_i[L4_LATE_BIT];
    ctl_o.wait_en      = wait_mode_i & word_i[L4_EARLY_BIT];
    ctl_o.late_capture = wait_mode_i & word_i[L4_LATE_BIT];
  end
endmodule

// File: rtl/strobe_seq_ctrl.sv
`timescale 1ns/1ps
module strobe_seq_ctrl
  import strobe_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  logic  waen_i,
  input  logic  wait_s_i,
  output half_t phase_o,
  output logic  frozen_o,
  output logic  load_early_o,
  output logic  load_late_o,
  output logic  go_idle_o
);
  half_t ph_q;
  logic  frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_FIRST;
      frozen_q <= 1'b0;
    end else if (frozen_q) begin
      if (!wait_s_i) frozen_q <= 1'b0;
    end else if (ph_q == PH_FIRST) begin
      if (valid_i) ph_q <= PH_SECOND;
    end else begin
      ph_q <= PH_FIRST;
      if (waen_i && wait_s_i) frozen_q <= 1'b1;
    end
  end

  assign phase_o      = ph_q;
  assign frozen_o     = frozen_q;
  assign load_early_o = !frozen_q && (ph_q == PH_FIRST) && valid_i;
  assign load_late_o  = !frozen_q && (ph_q == PH_SECOND);
  assign go_idle_o    = !frozen_q && (ph_q == PH_FIRST) && !valid_i;

  AST_FRZ_IN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |-> (ph_q == PH_FIRST)); // R8
  AST_FRZ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frozen_q) |-> $past(ph_q == PH_SECOND && waen_i && wait_s_i)); // R8
  AST_WORD_TWO_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SECOND) |=> (ph_q == PH_FIRST)); // R2
  AST_RESUME_ON_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frozen_q) |-> !$past(wait_s_i)); // R9
endmodule

// File: rtl/strobe_out_regs.sv
`timescale 1ns/1ps
module strobe_out_regs
  import strobe_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  step_ctl_t ctl_i,
  input  logic      read_i,
  input  logic      load_early_i,
  input  logic      load_late_i,
  input  logic      go_idle_i,
  input  logic      frozen_i,
  output logic      line4_o,
  output logic      line5_o,
  output logic      capture_o
);
  logic line4_q, line5_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line4_q <= 1'b1;
      line5_q <= 1'b1;
      cap_q   <= 1'b0;
    end else if (load_early_i) begin
      line4_q <= ctl_i.l4_early;
      line5_q <= ctl_i.l5_early;
      cap_q   <= read_i & ~ctl_i.late_capture;
    end else if (load_late_i) begin
      line4_q <= ctl_i.l4_late;
      line5_q <= ctl_i.l5_late;
      cap_q   <= read_i & ctl_i.late_capture;
    end else if (go_idle_i) begin
      line4_q <= 1'b1;
      line5_q <= 1'b1;
      cap_q   <= 1'b0;
    end else begin
      cap_q   <= 1'b0; // frozen: lines hold
    end
  end

  assign line4_o   = line4_q;
  assign line5_o   = line5_q;
  assign capture_o = cap_q;

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_i |=> ($stable(line4_q) && $stable(line5_q) && !cap_q)); // R8
  AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_idle_i |=> (line4_q && line5_q && !cap_q)); // R1
endmodule

// File: rtl/strobe_seq.sv
`timescale 1ns/1ps
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned L4_EARLY_BIT = 16,
  parameter int unsigned L4_LATE_BIT  = 17,
  parameter int unsigned L5_EARLY_BIT = 18,
  parameter int unsigned L5_LATE_BIT  = 19,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              read_i,
  input  logic              wait_mode_i,
  input  logic              wait_i,
  output logic              line4_o,
  output logic              line5_o,
  output logic              capture_o,
  output logic              stall_o,
  output logic              phase_o
);
  step_ctl_t ctl;
  half_t     phase;
  logic      wait_s, frozen, load_early, load_late, go_idle;

  strobe_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(wait_i),
    .sync_o (wait_s)
  );

  strobe_word_decode #(
    .WORD_W      (WORD_W),
    .L4_EARLY_BIT(L4_EARLY_BIT),
    .L4_LATE_BIT (L4_LATE_BIT),
    .L5_EARLY_BIT(L5_EARLY_BIT),
    .L5_LATE_BIT (L5_LATE_BIT)
  ) u_dec (
    .word_i     (word_i),
    .wait_mode_i(wait_mode_i),
    .ctl_o      (ctl)
  );

  strobe_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (word_valid_i),
    .waen_i      (ctl.wait_en),
    .wait_s_i    (wait_s),
    .phase_o     (phase),
    .frozen_o    (frozen),
    .load_early_o(load_early),
    .load_late_o (load_late),
    .go_idle_o   (go_idle)
  );

  strobe_out_regs u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl),
    .read_i      (read_i),
    .load_early_i(load_early),
    .load_late_i (load_late),
    .go_idle_i   (go_idle),
    .frozen_i    (frozen),
    .line4_o     (line4_o),
    .line5_o     (line5_o),
    .capture_o   (capture_o)
  );

  assign stall_o = frozen;
  assign phase_o = (phase == PH_SECOND);

  AST_WAIT_MODE_L4_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_mode_i && !stall_o) |=> line4_o); // R5
  AST_NO_STALL_MODE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_mode_i && !stall_o) |=> !stall_o); // R4
  AST_NO_STALL_WAEN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o && !stall_o && !ctl.wait_en) |=> !stall_o); // R7
endmodule

// File: tb/strobe_seq_bench.sv
`timescale 1ns/1ps
module strobe_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] word = '0;
  logic        rd = 1'b0;
  logic        mode = 1'b0;
  logic        wt = 1'b0;
  logic        line4, line5, cap, stall, phase;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  strobe_seq u_strobe_seq (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .word_valid_i(valid),
    .word_i      (word),
    .read_i      (rd),
    .wait_mode_i (mode),
    .wait_i      (wt),
    .line4_o     (line4),
    .line5_o     (line5),
    .capture_o   (cap),
    .stall_o     (stall),
    .phase_o     (phase)
  );

  // compare {line4, line5, capture, stall, phase}
  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {line4, line5, cap, stall, phase};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [3:0] b);
    logic [31:0] w;
    w = '0;
    w[16] = b[0];
    w[17] = b[1];
    w[18] = b[2];
    w[19] = b[3];
    return w;
  endfunction

  // called at a negedge with phase 0 and no stall
  task automatic run_word(input logic m, input logic [3:0] b, input logic r);
    logic e4, l4, ce, cl;
    mode  = m;
    word  = mk_word(b);
    rd    = r;
    valid = 1'b1;
    e4 = m ? 1'b1 : b[0];
    l4 = m ? 1'b1 : b[1];
    ce = r & (m ? ~b[1] : 1'b1);
    cl = r & (m ? b[1] : 1'b0);
    @(negedge clk);
    chk(m ? "R2 R3 R5 R6 R7 early" : "R2 R3 R4 R6 early", {e4, b[2], ce, 1'b0, 1'b1});
    @(negedge clk);
    chk(m ? "R2 R3 R5 R6 R7 late" : "R2 R3 R4 R6 late", {l4, b[3], cl, 1'b0, 1'b0});
  endtask

  task automatic go_idle(input int n);
    valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 idle", 5'b11000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 got=hang exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 5'b11000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 5'b11000);

    for (int w = 0; w < 2; w++) begin
      wt = w[0];
      go_idle(4);
      for (int m = 0; m < 2; m++)
        for (int b = 0; b < 16; b++)
          for (int r = 0; r < 2; r++) begin
            if (w == 1 && m == 1 && b[0]) continue;
            run_word(m[0], b[3:0], r[0]);
          end
    end

    // freeze: wait high long before the step, late capture selected
    mode = 1'b1;
    wt   = 1'b1;
    go_idle(3);
    run_word_freeze();

    go_idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic run_word_freeze();
    word  = mk_word(4'b1011);
    rd    = 1'b1;
    valid = 1'b1;
    @(negedge clk);
    chk("R8 early before freeze", 5'b10001);
    @(negedge clk);
    chk("R8 freeze entry", 5'b11110);
    word = mk_word(4'b0100);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 frozen hold", 5'b11010);
    end
    wt = 1'b0;
    @(negedge clk);
    chk("R9 release edge 1", 5'b11010);
    @(negedge clk);
    chk("R9 release edge 2", 5'b11010);
    @(negedge clk);
    chk("R9 release edge 3", 5'b11000);
    @(negedge clk);
    chk("R9 held word early", 5'b11101);
    @(negedge clk);
    chk("R9 held word late", 5'b10000);
  endtask
endmodule